// File: doc/BRIEF.md
# Camera Pixel Capture to Asynchronous SRAM

This block takes the parallel pixel port of a CMOS image sensor and writes every frame it receives into an external asynchronous SRAM of 256K 16-bit words. The pixel clock, the frame marker and the line marker come in asynchronous to the system clock. Each one passes through a synchroniser and then a deglitch filter. A level change on one of these inputs is accepted only after it has stayed in place for a programmable number of system clocks. Pixels are taken on the chosen edge of the filtered pixel clock while the line marker is high.

The position of each pixel in memory comes from a per-frame pixel index. In normal mode the index counts up from address zero. In flip mode the address starts at the top of the frame area and counts down, so the stored image is mirrored. A rising edge on the filtered frame marker starts a new frame. Pixels beyond the configured frame size are dropped.

Inside the block, captured pixels go to the SRAM write sequencer over a valid/ready handshake. A one-entry skid register sits between them. The sensor cannot be stalled, so the ready signal is never passed back to the sensor. With pixels spaced as R10 requires, the skid register is always ready when a pixel arrives. Each write takes three system clocks: address setup, write strobe, then hold.

Top module: `cam_capture_sram`

## Requirements
- R1: While reset is applied and after it is released with no sensor activity, the outputs are as follows: `sram_cs_n`, `sram_we_n`, `sram_oe_n`, `sram_bhe_n` and `sram_ble_n` are all 1, and `frame_done` is 0.
- R2: A pixel is captured only on a filtered pixel clock edge while the filtered line marker is high. With `edge_fall`=0 the capture edge is rising (0 to 1); with `edge_fall`=1 it is falling (1 to 0). Clock edges seen while the line marker is low write nothing.
- R3: After synchronisation, a change on `cam_pclk`, `cam_vsync` or `cam_href` that lasts fewer than `filt_len`+1 system clocks is ignored. It causes no capture, no frame start and no change of address.
- R4: A rising edge of the filtered frame marker starts a frame and resets the pixel index to 0. In normal mode (`flip_en`=0), pixel k of the frame (counting from 0) is written at address k.
- R5: In flip mode (`flip_en`=1), pixel k is written at address FRAME_WORDS-1-k.
- R6: Pixels with index FRAME_WORDS or higher in a frame are not written. No write ever reaches an address at or above FRAME_WORDS.
- R7: Each SRAM write follows this sequence:
  - Address and data are driven, with `sram_cs_n` low, for one full clock before `sram_we_n` goes low.
  - `sram_we_n` is low for exactly one clock, with address and data unchanged.
  - Address and `sram_cs_n` are held for one more clock after the strobe ends.
  - `sram_oe_n` stays 1 throughout.
- R8: Byte lanes depend on PIX_W:
  - PIX_W ≤ 8: `sram_ble_n` is low during a write and `sram_bhe_n` stays 1. The pixel is placed in data bits [7:0] and bits [15:8] are 0.
  - PIX_W > 8: both byte enables are low during a write.
- R9: `frame_done` is a one-clock pulse. It fires on a frame start that follows a frame in which at least one pixel was accepted. A frame start after a frame with no pixels gives no pulse.
- R10: With a pixel clock period of at least 6 system clocks and `filt_len`=0, no pixel is lost. A pixel captured while a write is in progress is held in the skid register, and its write starts straight after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock (asynchronous) |
| cam_vsync | input | 1 | Sensor frame marker, brief high pulse at frame start |
| cam_href | input | 1 | Sensor line marker, high during valid pixels |
| cam_data | input | PIX_W | Sensor pixel data |
| edge_fall | input | 1 | Capture edge select: 0 rising, 1 falling |
| flip_en | input | 1 | 1 stores the frame with a descending address |
| filt_len | input | FILT_W | Extra stable clocks required by the deglitch filters |
| sram_addr | output | 18 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low (held inactive) |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_bhe_n | output | 1 | SRAM upper byte enable, active low |
| sram_ble_n | output | 1 | SRAM lower byte enable, active low |
| frame_done | output | 1 | One-clock pulse at the end of a frame that had pixels |

## Verification
A pixel index that is wrong or fails to reset shows up within one frame: stored data appears at shifted addresses, the write count differs, or writes land above the frame area. If a filter lets a glitch through, the result is either an extra captured pixel or a false frame start. Both are visible at the first write after the glitch, as a data shift or a premature `frame_done`. A fault in the write sequencer shows within the same write cycle as a strobe without setup, a strobe longer than one clock, or an address that moves during the strobe or hold.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  localparam int SRAM_AW = 18;
  localparam int SRAM_DW = 16;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_SETUP,
    WS_STROBE,
    WS_HOLD
  } wr_state_e;

  typedef struct packed {
    logic [SRAM_AW-1:0] addr;
    logic [SRAM_DW-1:0] data;
  } sram_word_t;

endpackage

// File: rtl/cam_sig_filter.sv
module cam_sig_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter bit RST_VAL     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] filt_len,
  output logic             q
);

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   s;
  logic [CNT_W-1:0]       cnt;

  // metastability chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= {SYNC_STAGES{RST_VAL}};
    else        sync_r <= {sync_r[SYNC_STAGES-2:0], din};
  end

  assign s = sync_r[SYNC_STAGES-1];

  // a new level is accepted after filt_len+1 consecutive mismatching samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST_VAL;
      cnt <= '0;
    end else if (s == q) begin
      cnt <= '0;
    end else if (cnt >= filt_len) begin
      q   <= s;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FILT_SETTLE: assert property (@(posedge clk) disable iff (!rst_n) (filt_len != '0 && !$stable(q)) |=> ($stable(q) || !$stable(filt_len))); // R3

endmodule

// File: rtl/cam_addr_gen.sv
module cam_addr_gen
  import cam_cap_pkg::*;
#(
  parameter int FRAME_WORDS = 110592
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               pix_strobe,
  input  logic               flip_en,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [SRAM_AW-1:0] out_addr,
  output logic               frame_done
);

  localparam int                 IDX_W    = $clog2(FRAME_WORDS + 1);
  localparam logic [IDX_W-1:0]   IDX_FULL = IDX_W'(FRAME_WORDS);
  localparam logic [SRAM_AW-1:0] TOP_ADDR = SRAM_AW'(FRAME_WORDS - 1);

  logic [IDX_W-1:0] idx;
  logic             wrote_any;
  logic             full;

  assign full      = (idx == IDX_FULL);
  assign out_valid = pix_strobe && !full && !frame_start;
  assign out_addr  = flip_en ? (TOP_ADDR - SRAM_AW'(idx)) : SRAM_AW'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      wrote_any  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= frame_start && wrote_any;
      if (frame_start) begin
        idx       <= '0;
        wrote_any <= 1'b0;
      end else if (out_valid && out_ready) begin
        idx       <= idx + 1'b1;
        wrote_any <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (full && !frame_start) |=> full); // R6
  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_addr <= TOP_ADDR)); // R5

endmodule

// File: rtl/cam_sram_writer.sv
module cam_sram_writer
  import cam_cap_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SRAM_AW-1:0] in_addr,
  input  logic [PIX_W-1:0]   in_data,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [SRAM_DW-1:0] sram_wdata,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic               sram_cs_n,
  output logic               sram_bhe_n,
  output logic               sram_ble_n
);

  wr_state_e  st;
  sram_word_t skid_q;
  sram_word_t out_q;
  logic       skid_v;
  logic       load;

  // a write may start from idle or straight out of the hold phase
  assign load     = skid_v && (st == WS_IDLE || st == WS_HOLD);
  assign in_ready = !skid_v || load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skid_v <= 1'b0;
      skid_q <= '0;
    end else if (in_valid && in_ready) begin
      skid_v      <= 1'b1;
      skid_q.addr <= in_addr;
      skid_q.data <= SRAM_DW'(in_data);
    end else if (load) begin
      skid_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WS_IDLE;
      out_q <= '0;
    end else begin
      if (load) out_q <= skid_q;
      unique case (st)
        WS_IDLE:   if (load) st <= WS_SETUP;
        WS_SETUP:  st <= WS_STROBE;
        WS_STROBE: st <= WS_HOLD;
        WS_HOLD:   st <= load ? WS_SETUP : WS_IDLE;
        default:   st <= WS_IDLE;
      endcase
    end
  end

  assign sram_addr  = out_q.addr;
  assign sram_wdata = out_q.data;
  assign sram_cs_n  = (st == WS_IDLE);
  assign sram_we_n  = (st != WS_STROBE);
  assign sram_oe_n  = 1'b1;
  assign sram_ble_n = sram_cs_n;

  generate
    if (PIX_W > 8) begin : g_wide
      assign sram_bhe_n = sram_cs_n;
    end else begin : g_narrow
      assign sram_bhe_n = 1'b1;
    end
  endgenerate

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(sram_we_n) |-> ($stable(sram_addr) && $past(!sram_cs_n))); // R7
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n) !sram_we_n |=> sram_we_n); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sram_we_n) |-> (!sram_cs_n && $stable(sram_addr))); // R7
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !sram_we_n |-> (!sram_cs_n && sram_oe_n && $stable(sram_wdata))); // R7

endmodule

// File: rtl/cam_capture_sram.sv
module cam_capture_sram
  import cam_cap_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int FRAME_WORDS = 110592,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cam_pclk,
  input  logic               cam_vsync,
  input  logic               cam_href,
  input  logic [PIX_W-1:0]   cam_data,
  input  logic               edge_fall,
  input  logic               flip_en,
  input  logic [FILT_W-1:0]  filt_len,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [SRAM_DW-1:0] sram_wdata,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic               sram_cs_n,
  output logic               sram_bhe_n,
  output logic               sram_ble_n,
  output logic               frame_done
);

  localparam int NUM_REFS = 3;
  localparam int REF_PCLK = 0;
  localparam int REF_VS   = 1;
  localparam int REF_HREF = 2;

  logic [NUM_REFS-1:0] ref_raw;
  logic [NUM_REFS-1:0] ref_f;
  logic                pclk_d;
  logic                vs_d;
  logic                cap;
  logic                frame_start;
  logic                pix_strobe;
  logic                px_valid;
  logic                px_ready;
  logic [SRAM_AW-1:0]  px_addr;
  logic [PIX_W-1:0]    dsync [SYNC_STAGES];

  assign ref_raw[REF_PCLK] = cam_pclk;
  assign ref_raw[REF_VS]   = cam_vsync;
  assign ref_raw[REF_HREF] = cam_href;

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
      cam_sig_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (FILT_W),
        .RST_VAL     (1'b0)
      ) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ref_raw[g]),
        .filt_len (filt_len),
        .q        (ref_f[g])
      );
    end
  endgenerate

  // data bus follows the same synchroniser depth as the references
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) dsync[i] <= '0;
    end else begin
      dsync[0] <= cam_data;
      for (int i = 1; i < SYNC_STAGES; i++) dsync[i] <= dsync[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_d <= 1'b0;
      vs_d   <= 1'b0;
    end else begin
      pclk_d <= ref_f[REF_PCLK];
      vs_d   <= ref_f[REF_VS];
    end
  end

  assign cap         = edge_fall ? (pclk_d & ~ref_f[REF_PCLK]) : (~pclk_d & ref_f[REF_PCLK]);
  assign frame_start = ref_f[REF_VS] & ~vs_d;
  assign pix_strobe  = cap & ref_f[REF_HREF];

  cam_addr_gen #(
    .FRAME_WORDS (FRAME_WORDS)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_strobe  (pix_strobe),
    .flip_en     (flip_en),
    .out_ready   (px_ready),
    .out_valid   (px_valid),
    .out_addr    (px_addr),
    .frame_done  (frame_done)
  );

  cam_sram_writer #(
    .PIX_W (PIX_W)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (px_valid),
    .in_ready   (px_ready),
    .in_addr    (px_addr),
    .in_data    (dsync[SYNC_STAGES-1]),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_cs_n  (sram_cs_n),
    .sram_bhe_n (sram_bhe_n),
    .sram_ble_n (sram_ble_n)
  );

  AST_CAP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n) px_valid |-> ref_f[REF_HREF]); // R2

endmodule

// File: tb/cam_capture_sram_tb.sv
module cam_capture_sram_tb;

  localparam int FW    = 48;
  localparam int PIX_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cam_pclk = 1'b0;
  logic        cam_vsync = 1'b0;
  logic        cam_href = 1'b0;
  logic [7:0]  cam_data = '0;
  logic        edge_fall = 1'b0;
  logic        flip_en = 1'b0;
  logic [3:0]  filt_len = 4'd2;
  logic [17:0] sram_addr;
  logic [15:0] sram_wdata;
  logic        sram_we_n, sram_oe_n, sram_cs_n, sram_bhe_n, sram_ble_n;
  logic        frame_done;

  int n_vec = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int last_addr = -1;
  logic [15:0] mem [64];
  logic [7:0]  exp_pix [64];
  logic        p_we = 1'b1;
  logic        p_cs = 1'b1;
  logic [17:0] p_addr = '0;

  always #5 clk = ~clk;

  cam_capture_sram #(
    .PIX_W       (PIX_W),
    .FRAME_WORDS (FW),
    .FILT_W      (4),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cam_pclk   (cam_pclk),
    .cam_vsync  (cam_vsync),
    .cam_href   (cam_href),
    .cam_data   (cam_data),
    .edge_fall  (edge_fall),
    .flip_en    (flip_en),
    .filt_len   (filt_len),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_cs_n  (sram_cs_n),
    .sram_bhe_n (sram_bhe_n),
    .sram_ble_n (sram_ble_n),
    .frame_done (frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int k, input bit fl);
    return fl ? (FW - 1 - k) : k;
  endfunction

  // SRAM model and write-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) done_cnt++;
      if (!sram_we_n) begin
        check(p_we, "R7 strobe longer than one clock", 0, 1);
        check(!p_cs && p_addr == sram_addr, "R7 setup before strobe", int'(sram_addr), int'(p_addr));
        check(!sram_ble_n && sram_bhe_n && sram_wdata[15:8] == 8'h00 && sram_oe_n,
              "R8 byte lanes", int'({sram_ble_n, sram_bhe_n, sram_oe_n}), 3);
        check(int'(sram_addr) < FW, "R6 address range", int'(sram_addr), FW - 1);
        mem[sram_addr[5:0]] = sram_wdata;
        wr_cnt++;
        last_addr = int'(sram_addr);
      end
      if (!p_we && sram_we_n)
        check(!sram_cs_n && sram_addr == p_addr, "R7 hold after strobe", int'(sram_addr), int'(p_addr));
      p_we   = sram_we_n;
      p_cs   = sram_cs_n;
      p_addr = sram_addr;
    end
  end

  task automatic pix(input logic [7:0] d, input logic h, input int hp);
    cam_pclk = edge_fall;
    cam_data = d;
    cam_href = h;
    repeat (hp) @(negedge clk);
    cam_pclk = ~edge_fall;
    repeat (hp) @(negedge clk);
  endtask

  task automatic vsync_pulse(input int hp);
    cam_vsync = 1'b1;
    for (int i = 0; i < 3; i++) pix(8'($urandom), 1'b0, hp);
    cam_vsync = 1'b0;
    for (int i = 0; i < 2; i++) pix(8'($urandom), 1'b0, hp);
  endtask

  task automatic run_frame(input int lines, input int ppl, input int hp, input bit fl,
                           input bit ef, input int fln, input bit glitch, input string tag);
    int n;
    int w0;
    int d0;
    int nexp;
    flip_en   = fl;
    edge_fall = ef;
    filt_len  = 4'(fln);
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    w0 = wr_cnt;
    d0 = done_cnt;
    n  = 0;
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ppl; p++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (n < 64) exp_pix[n] = d;
        n++;
        pix(d, 1'b1, hp);
        if (glitch && l == 0 && p == 4) begin
          cam_vsync = 1'b1;
          @(negedge clk);
          cam_vsync = 1'b0;
          repeat (4) @(negedge clk);
          cam_pclk = edge_fall;
          @(negedge clk);
          cam_pclk = ~edge_fall;
          repeat (4) @(negedge clk);
        end
      end
      // pclk keeps toggling with the line marker low: nothing may be written (R2)
      pix(8'($urandom), 1'b0, hp);
      pix(8'($urandom), 1'b0, hp);
    end
    vsync_pulse(hp);
    repeat (30) @(negedge clk);
    nexp = (n < FW) ? n : FW;
    check(wr_cnt - w0 == nexp, {tag, " write count"}, wr_cnt - w0, nexp);
    check(done_cnt - d0 == 1, {"R9 frame_done after ", tag}, done_cnt - d0, 1);
    for (int k = 0; k < nexp; k++) begin
      int a;
      a = exp_addr(k, fl);
      check(mem[a] == {8'h00, exp_pix[k]}, {tag, " pixel data at mapped address"},
            int'(mem[a]), int'(exp_pix[k]));
    end
    check(last_addr == exp_addr(nexp - 1, fl), {tag, " last address"}, last_addr, exp_addr(nexp - 1, fl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held
    check(sram_cs_n && sram_we_n && sram_oe_n && sram_bhe_n && sram_ble_n && !frame_done,
          "R1 strobes idle in reset", int'({sram_cs_n, sram_we_n, sram_oe_n, sram_bhe_n, sram_ble_n}), 31);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n && sram_bhe_n && sram_ble_n && !frame_done,
          "R1 strobes idle after reset", int'({sram_cs_n, sram_we_n, sram_oe_n, sram_bhe_n, sram_ble_n}), 31);

    // R9: frame starts with no pixels in between give no frame_done
    vsync_pulse(8);
    vsync_pulse(8);
    repeat (20) @(negedge clk);
    check(done_cnt == 0, "R9 no pulse for empty frames", done_cnt, 0);
    check(wr_cnt == 0, "R2 no writes without line marker", wr_cnt, 0);

    // R4 R2: normal order, rising capture edge
    run_frame(3, 8, 8, 1'b0, 1'b0, 2, 1'b0, "R4 normal rising");
    // R5 R3 R2: flipped, falling edge, with glitches on frame marker and pixel clock
    run_frame(2, 10, 8, 1'b1, 1'b1, 2, 1'b1, "R5 R3 flipped falling glitch");
    // R6: overflow in normal mode
    run_frame(6, 10, 8, 1'b0, 1'b0, 1, 1'b0, "R6 overflow normal");
    // R6 R5: overflow in flip mode
    run_frame(5, 10, 8, 1'b1, 1'b0, 3, 1'b0, "R6 overflow flipped");
    // R10: fastest pixel spacing with no filtering
    run_frame(2, 12, 3, 1'b0, 1'b0, 0, 1'b0, "R10 fast pixels");
    // R2: falling edge in normal mode with random line lengths
    run_frame(3, 5 + int'($urandom % 4), 8, 1'b0, 1'b1, 1, 1'b0, "R2 falling normal");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule